// File: doc/BRIEF.md
# Tagged L1 Cache Request Engine

This block turns a single command (a start address, an element count and a go strobe) into a stream of tagged requests towards a pipelined L1 data-cache port. Each element is fetched from `base + index * STRIDE`. Each request carries a tag taken from a tag-indexed pending bitmap. The engine keeps issuing until every element has been answered, and it matches answers to requests by tag rather than by the order in which they arrive.

The cache port is staged. The write data for a request is presented one cycle after the request is accepted. The cache may reject the request two cycles after acceptance; a rejected tag keeps its address and is placed back into a replay set, and replays are issued before any new element. An abort input cancels the two requests still inside that window through two kill outputs. It also stops further issue and drains the requests that remain in flight. `busy` covers the whole command. `done` is a single-cycle pulse that marks a command that completed normally.

Top module: `tagLoadEngine`

## Requirements
- R1: After reset `busy`, `done`, `reqValid`, `s1Kill` and `s2Kill` are all 0.
- R2: New elements are requested in index order at `cmdBase + index * STRIDE`. `cmdGo` is ignored while `busy` is 1. The base, count, store flag and data are captured when a go is accepted.
- R3: A new element takes the lowest-numbered tag whose pending bit is clear, and a tag never exceeds the `TAG_W` bits (at most 6) of `reqTag`.
- R4: When every tag is pending and no replay is waiting, `reqValid` stays 0.
- R5: In the cycle after an acceptance, `s1Data` equals `cmdData XOR zero-extended address` of the accepted request, and `reqStore` repeats the captured store flag.
- R6: `s2Nack` asserted two cycles after an acceptance puts that tag into a replay set. A replay re-sends the same tag and address. Replays win over new elements, lowest tag first, and can be issued from the cycle after the rejection.
- R7: `respValid` with `respTag` clears that tag's pending bit, whatever order the responses arrive in. The freed tag can be allocated again in the next cycle.
- R8: `done` is a single-cycle pulse, seen two cycles after the cycle in which the last outstanding response arrives (or two cycles after the go when the count is 0). `busy` is 0 in the same cycle as the pulse.
- R9: A `cmdAbort` pulse raises `s1Kill` if a request was accepted in the previous cycle and `s2Kill` if one was accepted two cycles earlier. It blocks issue in that cycle and in every later cycle of the command, and it drops the replay set. `busy` stays 1 until the remaining requests have been answered, and no `done` follows.
- R10: `busy` is 1 from the cycle after an accepted go until the completion or drain, and `reqValid` is 0 whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdGo | input | 1 | Start a command (ignored while busy) |
| cmdBase | input | ADDR_W | Address of element 0 |
| cmdCount | input | CNT_W | Number of elements |
| cmdStore | input | 1 | Requests are stores |
| cmdData | input | DATA_W | Store data seed |
| cmdAbort | input | 1 | Cancel the command |
| reqValid | output | 1 | Request offered |
| reqReady | input | 1 | Cache accepts request |
| reqAddr | output | ADDR_W | Request address |
| reqTag | output | TAG_W | Request tag |
| reqStore | output | 1 | Request is a store |
| s1Data | output | DATA_W | Write data for last cycle's acceptance |
| s1Kill | output | 1 | Cancel last cycle's acceptance |
| s2Kill | output | 1 | Cancel acceptance of two cycles ago |
| s2Nack | input | 1 | Acceptance of two cycles ago rejected |
| respValid | input | 1 | Response present |
| respTag | input | TAG_W | Tag of the response |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command completed (one cycle) |

## Verification
The hardest case to reach from the ports is a rejection that arrives while every tag is already pending. In that case the replay must take the only issue slot, and new elements must stay stalled. The bench sweeps element counts over a four-tag configuration. It holds responses back at random, rejects about a quarter of requests, and returns responses from a random starting tag, so the full-bitmap stall, replays and out-of-order completion occur together. Abort pulses are placed where acceptances sit in both kill stages.

// File: rtl/reqEngPkg.sv
package reqEngPkg;

  localparam int MAX_TAG_W = 6;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_RUN   = 2'd1,
    ENG_DRAIN = 2'd2
  } engState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic                 loadCmd;   // go accepted this cycle
    logic                 accept;    // request handshake this cycle
    logic                 useReplay; // offered request is a replay
    logic [MAX_TAG_W-1:0] tag;       // tag of the offered request
  } engStrobe_t;

endpackage

// File: rtl/reqEngPick.sv
// Lowest set bit finder.
module reqEngPick #(
  parameter int N = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end

  assign any = |vec;

endmodule

// File: rtl/reqEngCtrl.sv
module reqEngCtrl
  import reqEngPkg::*;
#(
  parameter int TAG_W = 6,
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmdGo,
  input  logic [CNT_W-1:0]      cmdCount,
  input  logic                  cmdAbort,
  input  logic                  reqReady,
  input  logic                  s2Nack,
  input  logic                  respValid,
  input  logic [TAG_W-1:0]      respTag,
  output logic                  reqValid,
  output logic [TAG_W-1:0]      reqTag,
  output logic                  s1Kill,
  output logic                  s2Kill,
  output logic                  busy,
  output logic                  done,
  output logic [(1<<TAG_W)-1:0] pendVec,
  output engStrobe_t            strb
);

  localparam int NT = 1 << TAG_W;

  if (TAG_W > MAX_TAG_W) begin : gTagCheck
    $error("TAG_W exceeds the cache tag field");
  end

  engState_t        state, stateNext;
  logic [NT-1:0]    pend, pendNext, queued, queuedNext;
  logic [CNT_W-1:0] countReg, issued;
  logic             s1Valid, s2Valid;
  logic [TAG_W-1:0] s1Tag, s2Tag;
  logic             doneReg;

  logic             queuedAny, freeAny, canNew, useReplay, accept, nackHit;
  logic             goAccept, finishRun;
  logic [TAG_W-1:0] replayTag, newTag, issueTag;
  logic [NT-1:0]    setMask, respMask, killMask, replayMask, nackMask, dropMask;

  reqEngPick #(.N(NT), .IDX_W(TAG_W)) uReplayPick (
    .vec(queued), .any(queuedAny), .idx(replayTag)
  );

  reqEngPick #(.N(NT), .IDX_W(TAG_W)) uFreePick (
    .vec(~pend), .any(freeAny), .idx(newTag)
  );

  // issue selection
  assign canNew    = (issued < countReg) && freeAny;
  assign useReplay = queuedAny;
  assign issueTag  = useReplay ? replayTag : newTag;
  assign reqValid  = (state == ENG_RUN) && !cmdAbort && (queuedAny || canNew);
  assign reqTag    = issueTag;
  assign accept    = reqValid && reqReady;
  assign goAccept  = (state == ENG_IDLE) && cmdGo;

  // staged cancel and rejection
  assign s1Kill  = cmdAbort && s1Valid;
  assign s2Kill  = cmdAbort && s2Valid;
  assign nackHit = s2Valid && s2Nack && !cmdAbort;

  always_comb begin
    setMask    = '0;
    respMask   = '0;
    killMask   = '0;
    replayMask = '0;
    nackMask   = '0;
    if (accept && !useReplay) setMask = NT'(1) << newTag;
    if (accept && useReplay) replayMask = NT'(1) << replayTag;
    if (respValid) respMask = NT'(1) << respTag;
    if (s1Kill) killMask = killMask | (NT'(1) << s1Tag);
    if (s2Kill) killMask = killMask | (NT'(1) << s2Tag);
    if (nackHit) nackMask = NT'(1) << s2Tag;
  end

  assign dropMask   = cmdAbort ? queued : '0;
  assign pendNext   = (pend | setMask) & ~respMask & ~killMask & ~dropMask;
  assign queuedNext = cmdAbort ? '0 : ((queued & ~replayMask) | nackMask);

  assign finishRun = (issued == countReg) && (pend == '0) && !queuedAny;

  always_comb begin
    stateNext = state;
    case (state)
      ENG_IDLE:  if (cmdGo) stateNext = ENG_RUN;
      ENG_RUN: begin
        if (cmdAbort) stateNext = ENG_DRAIN;
        else if (finishRun) stateNext = ENG_IDLE;
      end
      ENG_DRAIN: if (pend == '0) stateNext = ENG_IDLE;
      default:   stateNext = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ENG_IDLE;
      pend     <= '0;
      queued   <= '0;
      countReg <= '0;
      issued   <= '0;
      s1Valid  <= 1'b0;
      s2Valid  <= 1'b0;
      s1Tag    <= '0;
      s2Tag    <= '0;
      doneReg  <= 1'b0;
    end else begin
      state   <= stateNext;
      pend    <= pendNext;
      queued  <= queuedNext;
      doneReg <= (state == ENG_RUN) && !cmdAbort && finishRun;
      if (goAccept) begin
        countReg <= cmdCount;
        issued   <= '0;
      end else if (accept && !useReplay) begin
        issued <= issued + CNT_W'(1);
      end
      s1Valid <= accept;
      s1Tag   <= issueTag;
      s2Valid <= s1Valid && !cmdAbort;
      s2Tag   <= s1Tag;
    end
  end

  assign busy    = (state != ENG_IDLE);
  assign done    = doneReg;
  assign pendVec = pend;

  always_comb begin
    strb           = '0;
    strb.loadCmd   = goAccept;
    strb.accept    = accept;
    strb.useReplay = useReplay;
    strb.tag       = MAX_TAG_W'(issueTag);
  end

endmodule

// File: rtl/reqEngData.sv
module reqEngData
  import reqEngPkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int STRIDE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  engStrobe_t        strb,
  input  logic [ADDR_W-1:0] cmdBase,
  input  logic              cmdStore,
  input  logic [DATA_W-1:0] cmdData,
  output logic [ADDR_W-1:0] reqAddr,
  output logic              reqStore,
  output logic [DATA_W-1:0] s1Data
);

  localparam int NT = 1 << TAG_W;

  logic [ADDR_W-1:0] nextAddr, s1Addr;
  logic [DATA_W-1:0] dataReg;
  logic              storeReg;
  logic [TAG_W-1:0]  tagIdx;
  logic [ADDR_W-1:0] addrTable [NT];

  assign tagIdx = strb.tag[TAG_W-1:0];

  // per-tag address storage, kept for replays
  for (genvar t = 0; t < NT; t++) begin : gAddrRow
    always_ff @(posedge clk) begin
      if (!rstN) addrTable[t] <= '0;
      else if (strb.accept && !strb.useReplay && (tagIdx == TAG_W'(t)))
        addrTable[t] <= nextAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextAddr <= '0;
      dataReg  <= '0;
      storeReg <= 1'b0;
      s1Addr   <= '0;
    end else begin
      if (strb.loadCmd) begin
        nextAddr <= cmdBase;
        dataReg  <= cmdData;
        storeReg <= cmdStore;
      end else if (strb.accept && !strb.useReplay) begin
        nextAddr <= nextAddr + ADDR_W'(STRIDE);
      end
      if (strb.accept) s1Addr <= reqAddr;
    end
  end

  assign reqAddr  = strb.useReplay ? addrTable[tagIdx] : nextAddr;
  assign reqStore = storeReg;
  assign s1Data   = dataReg ^ DATA_W'(s1Addr);

endmodule

// File: rtl/tagLoadEngine.sv
module tagLoadEngine
  import reqEngPkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 16,
  parameter int STRIDE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdGo,
  input  logic [ADDR_W-1:0] cmdBase,
  input  logic [CNT_W-1:0]  cmdCount,
  input  logic              cmdStore,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              cmdAbort,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [TAG_W-1:0]  reqTag,
  output logic              reqStore,
  output logic [DATA_W-1:0] s1Data,
  output logic              s1Kill,
  output logic              s2Kill,
  input  logic              s2Nack,
  input  logic              respValid,
  input  logic [TAG_W-1:0]  respTag,
  output logic              busy,
  output logic              done
);

  engStrobe_t              strb;
  logic [(1<<TAG_W)-1:0]   pendVec;

  reqEngCtrl #(.TAG_W(TAG_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdGo(cmdGo), .cmdCount(cmdCount),
    .cmdAbort(cmdAbort), .reqReady(reqReady), .s2Nack(s2Nack),
    .respValid(respValid), .respTag(respTag), .reqValid(reqValid),
    .reqTag(reqTag), .s1Kill(s1Kill), .s2Kill(s2Kill), .busy(busy),
    .done(done), .pendVec(pendVec), .strb(strb)
  );

  reqEngData #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STRIDE(STRIDE)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdBase(cmdBase),
    .cmdStore(cmdStore), .cmdData(cmdData), .reqAddr(reqAddr),
    .reqStore(reqStore), .s1Data(s1Data)
  );

endmodule

// File: rtl/tagLoadEngineChk.sv
module tagLoadEngineChk #(
  parameter int TAG_W = 6
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  reqValid,
  input logic                  reqReady,
  input logic [TAG_W-1:0]      reqTag,
  input logic                  s1Kill,
  input logic                  s2Kill,
  input logic                  busy,
  input logic                  done,
  input logic                  replaySel,
  input logic [(1<<TAG_W)-1:0] pendVec
);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !reqValid);

  assert_s1_kill_R9: assert property (@(posedge clk) disable iff (!rstN)
    s1Kill |-> $past(reqValid && reqReady));

  assert_s2_kill_R9: assert property (@(posedge clk) disable iff (!rstN)
    s2Kill |-> $past(reqValid && reqReady, 2));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_fresh_tag_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !replaySel) |-> !pendVec[reqTag]);

  assert_replay_tag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && replaySel) |-> pendVec[reqTag]);

  assert_full_stall_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((&pendVec) && !replaySel) |-> !reqValid);

endmodule

bind tagLoadEngine tagLoadEngineChk #(.TAG_W(TAG_W)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqTag(reqTag), .s1Kill(s1Kill), .s2Kill(s2Kill), .busy(busy),
  .done(done), .replaySel(strb.useReplay), .pendVec(pendVec)
);

// File: tb/tb_tagLoadEngine.sv
module tb_tagLoadEngine;

  localparam int CLK_PERIOD = 10;
  localparam int TAG_W  = 2;
  localparam int NT     = 1 << TAG_W;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 8;
  localparam int STRIDE = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdGo = 1'b0, cmdStore = 1'b0, cmdAbort = 1'b0;
  logic [ADDR_W-1:0] cmdBase = '0;
  logic [CNT_W-1:0]  cmdCount = '0;
  logic [DATA_W-1:0] cmdData = '0;
  logic reqReady = 1'b0, s2Nack = 1'b0, respValid = 1'b0;
  logic [TAG_W-1:0] respTag = '0;
  logic reqValid, reqStore, s1Kill, s2Kill, busy, done;
  logic [ADDR_W-1:0] reqAddr;
  logic [TAG_W-1:0]  reqTag;
  logic [DATA_W-1:0] s1Data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tagLoadEngine #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                  .CNT_W(CNT_W), .STRIDE(STRIDE)) dut (
    .clk(clk), .rstN(rstN), .cmdGo(cmdGo), .cmdBase(cmdBase),
    .cmdCount(cmdCount), .cmdStore(cmdStore), .cmdData(cmdData),
    .cmdAbort(cmdAbort), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqTag(reqTag), .reqStore(reqStore),
    .s1Data(s1Data), .s1Kill(s1Kill), .s2Kill(s2Kill), .s2Nack(s2Nack),
    .respValid(respValid), .respTag(respTag), .busy(busy), .done(done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // bench model
  logic [NT-1:0]     mOut, mQ;
  logic [ADDR_W-1:0] mAddr [NT];
  int                mAge [NT];
  int                mNext, mCount;
  bit                mRun, mBusy, mStore;
  logic [ADDR_W-1:0] mBase;
  logic [DATA_W-1:0] mData;
  bit                acc1, acc2;
  logic [TAG_W-1:0]  acc1Tag, acc2Tag;
  logic [ADDR_W-1:0] acc1Addr;
  int                doneIn, busyOffIn;
  int                killSeen, replaySeen, stallSeen, doneSeen;
  logic [15:0]       lfsr;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int lowestSet(input logic [NT-1:0] v);
    for (int i = 0; i < NT; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic step(input bit goIn, input bit abortIn, input bit readyRand,
                      input bit nackOn);
    bit doNack, doResp, acc, isReplay, doStart;
    int respSel, expTag;
    logic [ADDR_W-1:0] expAddr;
    bit expValid;
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    reqReady = readyRand ? (lfsr[0] | lfsr[1]) : 1'b1;
    doNack = acc2 && !abortIn && nackOn && lfsr[2] && lfsr[3];
    s2Nack = doNack;
    respSel = -1;
    if (lfsr[4] | lfsr[5]) begin
      for (int k = 0; k < NT; k++) begin
        int t;
        t = (int'(lfsr[7:6]) + k) % NT;
        if (respSel < 0 && mOut[t] && !mQ[t] && mAge[t] >= 3) respSel = t;
      end
    end
    doResp = (respSel >= 0);
    respValid = doResp;
    respTag = doResp ? TAG_W'(respSel) : '0;
    cmdGo = goIn;
    cmdAbort = abortIn;
    if (doneIn > 0) doneIn--;
    if (busyOffIn > 0) busyOffIn--;
    if (busyOffIn == 0) begin mBusy = 1'b0; busyOffIn = -1; end
    #1;
    // R9: staged kills
    check(s1Kill == (abortIn && acc1), "R9", "s1Kill", s1Kill, abortIn && acc1);
    check(s2Kill == (abortIn && acc2), "R9", "s2Kill", s2Kill, abortIn && acc2);
    if (s1Kill && s2Kill) killSeen++;
    // R4 / R10: offer expected
    expValid = mRun && !abortIn && (mQ != '0 || (mNext < mCount && mOut != '1));
    check(reqValid == expValid, "R4", "reqValid", reqValid, expValid);
    if (mRun && mQ == '0 && mOut == '1) stallSeen++;
    check(busy == mBusy, "R10", "busy", busy, mBusy);
    // R8: done timing
    check(done == (doneIn == 0), "R8", "done", done, doneIn == 0);
    if (done) doneSeen++;
    if (doneIn == 0) doneIn = -1;
    // R5: store data follows acceptance by one cycle
    if (acc1 && mStore)
      check(s1Data == (mData ^ DATA_W'(acc1Addr)), "R5", "s1Data", s1Data,
            mData ^ DATA_W'(acc1Addr));
    acc = reqValid && reqReady;
    isReplay = (mQ != '0);
    expTag = 0; expAddr = '0;
    if (acc) begin
      if (isReplay) begin
        expTag = lowestSet(mQ);
        expAddr = mAddr[expTag];
        replaySeen++;
        check(reqTag == TAG_W'(expTag), "R6", "replay tag", reqTag, expTag);
        check(reqAddr == expAddr, "R6", "replay addr", reqAddr, expAddr);
      end else begin
        expTag = lowestSet(~mOut);
        expAddr = mBase + ADDR_W'(mNext * STRIDE);
        check(reqTag == TAG_W'(expTag), "R3", "new tag", reqTag, expTag);
        check(reqAddr == expAddr, "R2", "new addr", reqAddr, expAddr);
      end
      check(reqStore == mStore, "R5", "reqStore", reqStore, mStore);
    end
    doStart = goIn && !busy;
    // model update at the clock edge
    for (int i = 0; i < NT; i++) mAge[i]++;
    if (doResp) mOut[respSel] = 1'b0;
    if (doNack) mQ[acc2Tag] = 1'b1;
    if (acc) begin
      if (isReplay) mQ[expTag] = 1'b0;
      else begin
        mOut[expTag] = 1'b1;
        mAddr[expTag] = expAddr;
        mNext++;
      end
      mAge[expTag] = 0;
    end
    if (abortIn) begin
      if (acc1) mOut[acc1Tag] = 1'b0;
      if (acc2) mOut[acc2Tag] = 1'b0;
      mOut = mOut & ~mQ;
      mQ = '0;
      if (mRun) begin
        mRun = 1'b0;
        if (mOut == '0) busyOffIn = 2;
      end
      acc1 = 1'b0;
    end else if (!mRun && mBusy && busyOffIn < 0 && mOut == '0) begin
      busyOffIn = 2;
    end
    acc2 = acc1; acc2Tag = acc1Tag;
    acc1 = acc; acc1Tag = TAG_W'(expTag); acc1Addr = expAddr;
    if (doStart) begin
      mRun = 1'b1; mBusy = 1'b1; mNext = 0;
      mCount = int'(cmdCount); mBase = cmdBase; mData = cmdData; mStore = cmdStore;
    end
    if (mRun && mNext == mCount && mOut == '0 && mQ == '0) begin
      mRun = 1'b0; doneIn = 2; busyOffIn = 2;
    end
  endtask

  task automatic runCmd(input logic [ADDR_W-1:0] base, input int count,
                        input bit store, input logic [DATA_W-1:0] data,
                        input bit readyRand, input bit nackOn,
                        input int abortAt, input int goAgainAt,
                        input logic [15:0] seed);
    int it;
    lfsr = seed;
    cmdBase = base; cmdCount = CNT_W'(count); cmdStore = store; cmdData = data;
    doneSeen = 0;
    step(1'b1, 1'b0, readyRand, nackOn);
    it = 1;
    while ((mBusy || doneIn >= 0) && it < 3000) begin
      if (it == goAgainAt) begin
        cmdBase = base + 16'h0100; cmdCount = CNT_W'(count + 3);
      end
      step(it == goAgainAt, it == abortAt, readyRand, nackOn);
      it++;
    end
    check(it < 3000, "R8", "command completion", it, 3000);
    step(1'b0, 1'b0, readyRand, nackOn);
    step(1'b0, 1'b0, readyRand, nackOn);
    check(doneSeen == ((abortAt > 0) ? 0 : 1), "R8", "done pulses", doneSeen,
          (abortAt > 0) ? 0 : 1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stimulus
    mOut = '0; mQ = '0; mRun = 0; mBusy = 0; mStore = 0; mNext = 0; mCount = 0;
    mBase = '0; mData = '0; acc1 = 0; acc2 = 0; acc1Tag = '0; acc2Tag = '0;
    acc1Addr = '0; doneIn = -1; busyOffIn = -1;
    killSeen = 0; replaySeen = 0; stallSeen = 0; doneSeen = 0; lfsr = 16'h1;
    for (int i = 0; i < NT; i++) begin mAddr[i] = '0; mAge[i] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    check(done == 1'b0, "R1", "done after reset", done, 0);
    check(reqValid == 1'b0, "R1", "reqValid after reset", reqValid, 0);
    check(!s1Kill && !s2Kill, "R1", "kills after reset", s1Kill | s2Kill, 0);

    // sweep of counts; R2 R3 R4 R5 R6 R7 R8 R10
    for (int n = 0; n <= 12; n++) begin
      runCmd(16'h1000 + 16'(n * 64), n, n[0], 16'hA5C3 ^ 16'(n), n[1],
             n >= 3, -1, -1, 16'hACE1 + 16'(n * 97));
    end
    // R2: go during a run is ignored
    runCmd(16'h2000, 14, 1'b1, 16'h5A5A, 1'b1, 1'b1, -1, 5, 16'h3C3C);
    // R9: abort with acceptances in both kill stages
    runCmd(16'h3000, 12, 1'b0, 16'h0000, 1'b0, 1'b0, 3, -1, 16'h7777);
    runCmd(16'h4000, 20, 1'b1, 16'h1234, 1'b0, 1'b1, 9, -1, 16'h2468);
    // R7 / R6 / R4 coverage of the hard cases
    check(killSeen >= 1, "R9", "double kill observed", killSeen, 1);
    check(replaySeen >= 1, "R6", "replays observed", replaySeen, 1);
    check(stallSeen >= 1, "R4", "full-tag stalls observed", stallSeen, 1);
    check(mOut == '0, "R7", "all tags answered", mOut, 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule